// File: doc/BRIEF.md
# I2C Master Address-Format Sequencer

This block is a single-master I2C transfer engine. One start command runs a whole transfer on open-drain clock and data lines: a START condition, an address header, a series of data characters each followed by an acknowledge clock, and a closing STOP. The host chooses the header form per transfer. It can send a 7-bit address with the direction bit, a 10-bit address carried in two header bytes, or no address at all (free format). A 10-bit read inserts a repeated START by itself and sends a short header again with the direction bit set.

Data characters are 1 to 8 bits wide. Writes take their characters through a request/valid handshake. Reads return each character on a one-cycle valid strobe. A NACK from the slave on any master-sent byte ends the transfer with a STOP and raises a flag. Each SCL half-period lasts a programmable number of system clocks.

Top module: `i2c_frame_master`

## Requirements
- R1: While reset is asserted and after it is released, neither line is pulled low, and `busy`, `done`, `nack`, `rxValid` and `txNeed` are 0.
- R2: With `wideAddr`=0 and `freeFmt`=0, the first byte after START is `slaveAddr[6:0]` followed by `rnw`, sent MSB first, and then one acknowledge clock.
- R3: `rnw`=0 makes the master send data characters and request each one with `txNeed`; `rnw`=1 makes it receive them and present each on `rxData` with a one-cycle `rxValid`.
- R4: Every character is followed by exactly one extra SCL clock for the acknowledge bit, driven low by whichever side received the character.
- R5: The data character width is `bitCount` (1 to 8; 0 or more than 8 gives 8). A sent character is `txData[n-1:0]`, MSB first, and its upper bits are ignored. A received character sits in `rxData[n-1:0]` with zeros above. Address bytes are always 8 bits.
- R6: With `wideAddr`=1 and `freeFmt`=0, the header is the byte 11110,`slaveAddr[9:8]`,0 followed by the byte `slaveAddr[7:0]`, and each byte is acknowledged. For a write, data follows directly.
- R7: A 10-bit read sends the two header bytes, then a repeated START, then the byte 11110,`slaveAddr[9:8]`,1 with its acknowledge, and then receives data.
- R8: With `freeFmt`=1, data characters follow START directly with no address byte, and `wideAddr` has no effect.
- R9: A high acknowledge bit after an address byte or a master-sent character sets `nack`. No further character is requested or sent, and STOP follows.
- R10: When receiving, the master drives acknowledge low after every character except the last, where it leaves SDA high.
- R11: SDA changes while SCL is high only to form START (fall), repeated START (fall) or STOP (rise). After STOP both lines are released.
- R12: SCL stays high for exactly `halfPeriod` system clocks in every data or acknowledge bit.
- R13: A `charCount` of 0 sends the header (or nothing in free format) and then STOP.
- R14: `busy` is high from the cycle after `start` until the transfer ends, and `done` pulses for exactly one cycle at the end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a transfer when idle; the transfer settings below are captured on it |
| wideAddr | input | 1 | Selects the 10-bit address header |
| freeFmt | input | 1 | Skips the address header |
| rnw | input | 1 | 1 = read from slave, 0 = write to slave |
| slaveAddr | input | 10 | Slave address; bits 6:0 used in 7-bit mode |
| bitCount | input | 4 | Data character width |
| charCount | input | CNT_W | Number of data characters |
| halfPeriod | input | DIV_W | System clocks per SCL half-period; hold stable during a transfer |
| txData | input | 8 | Write character |
| txValid | input | 1 | `txData` valid; taken while `txNeed` is high |
| sdaIn | input | 1 | Sensed SDA line level |
| sclOe | output | 1 | 1 pulls SCL low |
| sdaOe | output | 1 | 1 pulls SDA low |
| txNeed | output | 1 | Waiting for the next write character |
| rxData | output | 8 | Received character |
| rxValid | output | 1 | One-cycle strobe for `rxData` |
| nack | output | 1 | Set when the slave refused; cleared by the next `start` |
| done | output | 1 | One-cycle end-of-transfer pulse |
| busy | output | 1 | Transfer in progress |

## Verification
The hardest case to reach from the ports is the 10-bit read turnaround. Reaching it takes two header bytes that the slave acknowledges and a repeated START whose SDA fall must come while SCL is high. Then a shortened header has to go out with the direction bit flipped, and only after that does the slave drive data. The bench model of the slave releases or pulls SDA after each SCL fall from a queue of per-clock drive values. These values are built from the expected frame, so the slave can acknowledge, refuse, or supply read bits exactly where the frame needs them. NACK cases use the same queue: a released acknowledge is placed on the address byte, or in the middle of a write.

// File: rtl/i2cfm_pkg.sv
`timescale 1ns/1ps
package i2cfm_pkg;

  localparam int CHAR_W = 8;
  localparam logic [4:0] WIDE_TAG = 5'b11110;

  typedef enum logic [1:0] {
    LOP_START,
    LOP_BIT,
    LOP_RSTART,
    LOP_STOP
  } lineOp_e;

  typedef struct packed {
    logic              go;
    lineOp_e           op;
    logic              load;
    logic [CHAR_W-1:0] loadVal;
    logic              useShift;
    logic              fixedBit;
  } lineCmd_t;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_START,
    ST_HDR,
    ST_HACK,
    ST_RSTART,
    ST_WAITTX,
    ST_DATA,
    ST_DACK,
    ST_STOP
  } ctrlState_e;

endpackage

// File: rtl/i2cfm_dp.sv
`timescale 1ns/1ps
module i2cfm_dp
  import i2cfm_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  lineCmd_t          cmd,
  input  logic [DIV_W-1:0]  halfPeriod,
  input  logic              sdaIn,
  output logic              sclLow,
  output logic              sdaLow,
  output logic              opDone,
  output logic              sampled,
  output logic [CHAR_W-1:0] shiftReg
);

  logic             busy;
  lineOp_e          opReg;
  logic             useShiftReg;
  logic [1:0]       step;
  logic [DIV_W-1:0] timer;
  logic             firstBit;
  logic             stepEnd;

  assign firstBit = cmd.useShift ? (cmd.load ? cmd.loadVal[CHAR_W-1] : shiftReg[CHAR_W-1])
                                 : cmd.fixedBit;
  assign stepEnd  = busy && (timer == halfPeriod - DIV_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy        <= 1'b0;
      opReg       <= LOP_STOP;
      useShiftReg <= 1'b0;
      step        <= '0;
      timer       <= '0;
      sclLow      <= 1'b0;
      sdaLow      <= 1'b0;
      opDone      <= 1'b0;
      sampled     <= 1'b1;
      shiftReg    <= '1;
    end else begin
      opDone <= 1'b0;
      if (cmd.go && !busy) begin
        busy        <= 1'b1;
        opReg       <= cmd.op;
        useShiftReg <= cmd.useShift;
        step        <= '0;
        timer       <= '0;
        if (cmd.load) shiftReg <= cmd.loadVal;
        case (cmd.op)
          LOP_START:  sdaLow <= 1'b1;
          LOP_BIT:    sdaLow <= ~firstBit;
          LOP_RSTART: sdaLow <= 1'b0;
          default:    sdaLow <= 1'b1;
        endcase
      end else if (stepEnd) begin
        timer <= '0;
        step  <= step + 2'd1;
        case (opReg)
          LOP_START: begin
            sclLow <= 1'b1;
            busy   <= 1'b0;
            opDone <= 1'b1;
          end
          LOP_BIT: begin
            if (step == 2'd0) begin
              sclLow <= 1'b0;
            end else begin
              sampled <= sdaIn;
              sclLow  <= 1'b1;
              if (useShiftReg) shiftReg <= {shiftReg[CHAR_W-2:0], sdaIn};
              busy   <= 1'b0;
              opDone <= 1'b1;
            end
          end
          LOP_RSTART: begin
            if (step == 2'd0) sclLow <= 1'b0;
            else if (step == 2'd1) sdaLow <= 1'b1;
            else begin
              sclLow <= 1'b1;
              busy   <= 1'b0;
              opDone <= 1'b1;
            end
          end
          default: begin
            if (step == 2'd0) sclLow <= 1'b0;
            else if (step == 2'd1) sdaLow <= 1'b0;
            else begin
              busy   <= 1'b0;
              opDone <= 1'b1;
            end
          end
        endcase
      end else if (busy) begin
        timer <= timer + DIV_W'(1);
      end
    end
  end

  // R11: with SCL held high, SDA may only move inside a START, repeated START or STOP op
  assert_sda_edge_scl_low_R11: assert property (@(posedge clk) disable iff (!rstN)
    (!sclLow && !$past(sclLow) && (sdaLow != $past(sdaLow))) |-> (opReg != LOP_BIT));

  // R11: the control never launches a line op while one is still running
  assert_go_when_idle_R11: assert property (@(posedge clk) disable iff (!rstN)
    cmd.go |-> !busy);

endmodule

// File: rtl/i2cfm_ctrl.sv
`timescale 1ns/1ps
module i2cfm_ctrl
  import i2cfm_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              wideAddr,
  input  logic              freeFmt,
  input  logic              rnw,
  input  logic [9:0]        slaveAddr,
  input  logic [3:0]        bitCount,
  input  logic [CNT_W-1:0]  charCount,
  input  logic [CHAR_W-1:0] txData,
  input  logic              txValid,
  input  logic              opDone,
  input  logic              sampled,
  input  logic [CHAR_W-1:0] shiftIn,
  output lineCmd_t          cmd,
  output logic              txNeed,
  output logic [CHAR_W-1:0] rxData,
  output logic              rxValid,
  output logic              nack,
  output logic              done,
  output logic              busy
);

  ctrlState_e        state;
  logic              issued;
  logic [3:0]        bitIdx;
  logic [1:0]        hdrStep;
  logic [CNT_W-1:0]  charLeft;
  logic              wideR, freeR, rnwR;
  logic [9:0]        addrR;
  logic [3:0]        nBits;
  logic [CHAR_W-1:0] txWord;
  logic [CHAR_W-1:0] hdrByte;
  logic [CHAR_W-1:0] txAligned;
  logic [CHAR_W-1:0] rxMask;
  logic              needsOp;

  function automatic ctrlState_e dataEntry(input logic [CNT_W-1:0] cnt, input logic rd);
    if (cnt == '0) return ST_STOP;
    else if (rd)   return ST_DATA;
    else           return ST_WAITTX;
  endfunction

  always_comb begin
    case (hdrStep)
      2'd0:    hdrByte = wideR ? {WIDE_TAG, addrR[9:8], 1'b0} : {addrR[6:0], rnwR};
      2'd1:    hdrByte = addrR[7:0];
      default: hdrByte = {WIDE_TAG, addrR[9:8], 1'b1};
    endcase
  end

  assign txAligned = CHAR_W'(txWord << (4'd8 - nBits));
  assign rxMask    = CHAR_W'(8'hFF >> (4'd8 - nBits));
  assign needsOp   = (state != ST_IDLE) && (state != ST_WAITTX);
  assign txNeed    = (state == ST_WAITTX);
  assign busy      = (state != ST_IDLE);

  always_comb begin
    cmd    = '0;
    cmd.go = needsOp && !issued;
    case (state)
      ST_START:  cmd.op = LOP_START;
      ST_RSTART: cmd.op = LOP_RSTART;
      ST_STOP:   cmd.op = LOP_STOP;
      ST_HDR: begin
        cmd.op       = LOP_BIT;
        cmd.useShift = 1'b1;
        cmd.load     = (bitIdx == 4'd0);
        cmd.loadVal  = hdrByte;
      end
      ST_HACK: begin
        cmd.op       = LOP_BIT;
        cmd.fixedBit = 1'b1;
      end
      ST_DATA: begin
        cmd.op       = LOP_BIT;
        cmd.useShift = 1'b1;
        cmd.load     = (bitIdx == 4'd0);
        cmd.loadVal  = rnwR ? '1 : txAligned;
      end
      ST_DACK: begin
        cmd.op       = LOP_BIT;
        cmd.fixedBit = rnwR ? (charLeft == CNT_W'(1)) : 1'b1;
      end
      default: cmd.op = LOP_STOP;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      issued   <= 1'b0;
      bitIdx   <= '0;
      hdrStep  <= '0;
      charLeft <= '0;
      wideR    <= 1'b0;
      freeR    <= 1'b0;
      rnwR     <= 1'b0;
      addrR    <= '0;
      nBits    <= 4'd8;
      txWord   <= '0;
      rxData   <= '0;
      rxValid  <= 1'b0;
      nack     <= 1'b0;
      done     <= 1'b0;
    end else begin
      rxValid <= 1'b0;
      done    <= 1'b0;
      if (state == ST_IDLE) begin
        if (start) begin
          wideR    <= wideAddr;
          freeR    <= freeFmt;
          rnwR     <= rnw;
          addrR    <= slaveAddr;
          charLeft <= charCount;
          nBits    <= ((bitCount == 4'd0) || (bitCount > 4'd8)) ? 4'd8 : bitCount;
          nack     <= 1'b0;
          hdrStep  <= '0;
          bitIdx   <= '0;
          issued   <= 1'b0;
          state    <= ST_START;
        end
      end else if (state == ST_WAITTX) begin
        if (txValid) begin
          txWord <= txData;
          bitIdx <= '0;
          state  <= ST_DATA;
        end
      end else if (cmd.go) begin
        issued <= 1'b1;
      end else if (opDone) begin
        issued <= 1'b0;
        case (state)
          ST_START: state <= freeR ? dataEntry(charLeft, rnwR) : ST_HDR;
          ST_HDR: begin
            if (bitIdx == 4'd7) begin
              bitIdx <= '0;
              state  <= ST_HACK;
            end else begin
              bitIdx <= bitIdx + 4'd1;
            end
          end
          ST_HACK: begin
            if (sampled) begin
              nack  <= 1'b1;
              state <= ST_STOP;
            end else if ((hdrStep == 2'd0) && wideR) begin
              hdrStep <= 2'd1;
              state   <= ST_HDR;
            end else if ((hdrStep == 2'd1) && rnwR) begin
              state <= ST_RSTART;
            end else begin
              state <= dataEntry(charLeft, rnwR);
            end
          end
          ST_RSTART: begin
            hdrStep <= 2'd2;
            state   <= ST_HDR;
          end
          ST_DATA: begin
            if (bitIdx == nBits - 4'd1) begin
              bitIdx <= '0;
              state  <= ST_DACK;
              if (rnwR) begin
                rxData  <= shiftIn & rxMask;
                rxValid <= 1'b1;
              end
            end else begin
              bitIdx <= bitIdx + 4'd1;
            end
          end
          ST_DACK: begin
            charLeft <= charLeft - CNT_W'(1);
            if (!rnwR && sampled) begin
              nack  <= 1'b1;
              state <= ST_STOP;
            end else begin
              state <= dataEntry(charLeft - CNT_W'(1), rnwR);
            end
          end
          ST_STOP: begin
            done  <= 1'b1;
            state <= ST_IDLE;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  // R3: write characters are only requested in a write transfer
  assert_tx_only_write_R3: assert property (@(posedge clk) disable iff (!rstN)
    txNeed |-> !rnwR);

  // R3: read strobes only appear in a read transfer
  assert_rx_only_read_R3: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |-> rnwR);

  // R9: a refused header byte leads straight to STOP with the flag set
  assert_nack_ends_R9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HACK && issued && opDone && sampled) |=> (state == ST_STOP && nack));

  // R14: the end pulse lasts one cycle and leaves the block idle
  assert_done_pulse_R14: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

endmodule

// File: rtl/i2c_frame_master.sv
`timescale 1ns/1ps
module i2c_frame_master
  import i2cfm_pkg::*;
#(
  parameter int DIV_W = 16,
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              wideAddr,
  input  logic              freeFmt,
  input  logic              rnw,
  input  logic [9:0]        slaveAddr,
  input  logic [3:0]        bitCount,
  input  logic [CNT_W-1:0]  charCount,
  input  logic [DIV_W-1:0]  halfPeriod,
  input  logic [7:0]        txData,
  input  logic              txValid,
  input  logic              sdaIn,
  output logic              sclOe,
  output logic              sdaOe,
  output logic              txNeed,
  output logic [7:0]        rxData,
  output logic              rxValid,
  output logic              nack,
  output logic              done,
  output logic              busy
);

  lineCmd_t          cmd;
  logic              opDone;
  logic              sampled;
  logic [CHAR_W-1:0] shiftReg;

  i2cfm_ctrl #(.CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .wideAddr(wideAddr), .freeFmt(freeFmt),
    .rnw(rnw), .slaveAddr(slaveAddr), .bitCount(bitCount), .charCount(charCount),
    .txData(txData), .txValid(txValid), .opDone(opDone), .sampled(sampled),
    .shiftIn(shiftReg), .cmd(cmd), .txNeed(txNeed), .rxData(rxData),
    .rxValid(rxValid), .nack(nack), .done(done), .busy(busy)
  );

  i2cfm_dp #(.DIV_W(DIV_W)) uDp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .halfPeriod(halfPeriod), .sdaIn(sdaIn),
    .sclLow(sclOe), .sdaLow(sdaOe), .opDone(opDone), .sampled(sampled),
    .shiftReg(shiftReg)
  );

endmodule

// File: tb/sim_i2c_frame_master.sv
`timescale 1ns/1ps
module sim_i2c_frame_master;

  localparam int DIV_W = 16;
  localparam int CNT_W = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN, start, wideAddr, freeFmt, rnw, txValid;
  logic [9:0] slaveAddr;
  logic [3:0] bitCount;
  logic [CNT_W-1:0] charCount;
  logic [DIV_W-1:0] halfPeriod;
  logic [7:0] txData, rxData;
  logic sclOe, sdaOe, txNeed, rxValid, nack, done, busy;
  logic slaveLow = 1'b0;
  logic sclLine, sdaLine;

  assign sclLine = !sclOe;
  assign sdaLine = !(sdaOe || slaveLow);

  i2c_frame_master #(.DIV_W(DIV_W), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .wideAddr(wideAddr), .freeFmt(freeFmt),
    .rnw(rnw), .slaveAddr(slaveAddr), .bitCount(bitCount), .charCount(charCount),
    .halfPeriod(halfPeriod), .txData(txData), .txValid(txValid), .sdaIn(sdaLine),
    .sclOe(sclOe), .sdaOe(sdaOe), .txNeed(txNeed), .rxData(rxData), .rxValid(rxValid),
    .nack(nack), .done(done), .busy(busy)
  );

  int total = 0;
  int bad = 0;
  int expQ[$];
  string tagQ[$];
  int drvQ[$];
  logic [7:0] txQ[$];
  logic [7:0] rxQ[$];
  bit monOn = 1'b0;
  bit skipFall = 1'b0;
  int cyc = 0;
  int riseCyc = 0;
  int hp = 4;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // scoreboard monitor: events 0/1 = bit at SCL fall, 2 = START, 3 = STOP
  task automatic seeEvent(input int ev);
    int e;
    string t;
    if (expQ.size() == 0) begin
      chk(1'b0, "R11 unexpected bus event", ev, -1);
    end else begin
      e = expQ.pop_front();
      t = tagQ.pop_front();
      chk(ev == e, t, ev, e);
    end
  endtask

  always @(posedge clk) cyc++;

  always @(negedge sdaLine) if (monOn && sclLine === 1'b1) begin
    skipFall = 1'b1;
    seeEvent(2);
  end

  always @(posedge sdaLine) if (monOn && sclLine === 1'b1) seeEvent(3);

  always @(posedge sclLine) riseCyc = cyc;

  always @(negedge sclLine) if (monOn) begin
    if (skipFall) skipFall = 1'b0;
    else begin
      seeEvent(sdaLine ? 1 : 0);
      chk((cyc - riseCyc) == hp, "R12 SCL high time", cyc - riseCyc, hp);
    end
  end

  // slave model: after each SCL fall, apply the next drive value (0 = pull low)
  always @(negedge sclLine) if (monOn) begin
    int v;
    v = (drvQ.size() > 0) ? drvQ.pop_front() : 1;
    #2 slaveLow = (v == 0);
  end

  // write-character driver
  always @(negedge clk) begin
    if (txValid) txValid = 1'b0;
    else if (txNeed && txQ.size() > 0) begin
      txData  = txQ.pop_front();
      txValid = 1'b1;
    end
  end

  // read-character checker
  always @(negedge clk) if (rxValid) begin
    if (rxQ.size() == 0) chk(1'b0, "R3 unexpected read strobe", rxData, -1);
    else begin
      logic [7:0] e;
      e = rxQ.pop_front();
      chk(rxData == e, "R3 R5 read character", rxData, e);
    end
  end

  task automatic pushEv(input int ev, input string t);
    expQ.push_back(ev);
    tagQ.push_back(t);
  endtask

  task automatic pushByte(input logic [7:0] v, input int nb, input bit slaveSends, input string t);
    for (int i = nb - 1; i >= 0; i--) begin
      pushEv(int'(v[i]), t);
      drvQ.push_back(slaveSends ? int'(v[i]) : 1);
    end
  endtask

  task automatic pushAck(input bit b, input bit slaveSends, input string t);
    pushEv(int'(b), {t, " R4 ack"});
    drvQ.push_back(slaveSends ? int'(b) : 1);
  endtask

  task automatic runXfer(input bit wide, input bit free, input bit rw, input logic [9:0] addr,
                         input int n, input int cnt, input int nackAt, input int hpv,
                         input string t);
    int neff;
    int leftTx;
    bit stopNow;
    bit got;
    logic [7:0] v;
    logic [7:0] mask;
    neff = (n == 0 || n > 8) ? 8 : n;
    mask = 8'(8'hFF >> (8 - neff));
    hp = hpv;
    stopNow = 1'b0;
    leftTx = 0;
    pushEv(2, {t, " START"});
    if (!free) begin
      if (!wide) pushByte({addr[6:0], rw}, 8, 1'b0, {t, " R2 header"});
      else       pushByte({5'b11110, addr[9:8], 1'b0}, 8, 1'b0, {t, " R6 header1"});
      if (nackAt == 0) begin
        pushAck(1'b1, 1'b1, t);
        stopNow = 1'b1;
      end else pushAck(1'b0, 1'b1, t);
      if (!stopNow && wide) begin
        pushByte(addr[7:0], 8, 1'b0, {t, " R6 header2"});
        pushAck(1'b0, 1'b1, t);
        if (rw) begin
          drvQ.push_back(1);
          pushEv(2, {t, " R7 repeated START"});
          pushByte({5'b11110, addr[9:8], 1'b1}, 8, 1'b0, {t, " R7 header3"});
          pushAck(1'b0, 1'b1, t);
        end
      end
    end
    if (!rw) for (int i = 0; i < cnt; i++) txQ.push_back(8'hC3 ^ 8'(i * 41));
    if (!rw && stopNow) leftTx = cnt;
    if (!stopNow) begin
      for (int i = 0; i < cnt; i++) begin
        if (!rw) begin
          v = 8'hC3 ^ 8'(i * 41);
          pushByte(v, neff, 1'b0, {t, " R5 write bits"});
          if (nackAt == i + 1) begin
            pushAck(1'b1, 1'b1, t);
            leftTx = cnt - i - 1;
            break;
          end else pushAck(1'b0, 1'b1, t);
        end else begin
          v = (8'h5A + 8'(i * 51)) & mask;
          rxQ.push_back(v);
          pushByte(v, neff, 1'b1, {t, " R5 read bits"});
          pushAck(i == cnt - 1, 1'b0, {t, " R10"});
        end
      end
    end
    drvQ.push_back(1);
    pushEv(3, {t, " R11 STOP"});

    @(negedge clk);
    wideAddr = wide; freeFmt = free; rnw = rw; slaveAddr = addr;
    bitCount = 4'(n); charCount = CNT_W'(cnt); halfPeriod = DIV_W'(hpv);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, {t, " R14 busy after start"}, busy, 1);
    got = 1'b0;
    for (int k = 0; k < 40000; k++) begin
      @(negedge clk);
      if (done) begin
        got = 1'b1;
        break;
      end
    end
    chk(got, {t, " R14 done seen"}, got, 1);
    chk(nack == (nackAt >= 0), {t, " R9 nack flag"}, nack, nackAt >= 0);
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, {t, " R14 done one cycle"}, done, 0);
    repeat (hpv + 4) @(negedge clk);
    chk(sclLine == 1'b1 && sdaLine == 1'b1, {t, " R11 lines released"}, {sclLine, sdaLine}, 3);
    chk(expQ.size() == 0, {t, " frame complete"}, expQ.size(), 0);
    chk(rxQ.size() == 0, {t, " R3 all reads seen"}, rxQ.size(), 0);
    chk(txQ.size() == leftTx, {t, " R9 write requests"}, txQ.size(), leftTx);
    expQ.delete(); tagQ.delete(); drvQ.delete(); txQ.delete(); rxQ.delete();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rstN = 1'b0; start = 1'b0; wideAddr = 1'b0; freeFmt = 1'b0; rnw = 1'b0;
    slaveAddr = '0; bitCount = 4'd8; charCount = '0; halfPeriod = DIV_W'(4);
    txData = '0; txValid = 1'b0;
    repeat (4) @(negedge clk);
    chk(sclOe == 1'b0 && sdaOe == 1'b0, "R1 lines released in reset", {sclOe, sdaOe}, 0);
    chk(!busy && !done && !nack && !rxValid && !txNeed, "R1 flags clear in reset",
        {busy, done, nack, rxValid, txNeed}, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk(sclOe == 1'b0 && sdaOe == 1'b0 && !busy, "R1 idle after reset", {sclOe, sdaOe, busy}, 0);
    monOn = 1'b1;

    runXfer(1'b0, 1'b0, 1'b0, 10'h05A, 8, 3, -1, 4, "R2 R3 7-bit write");
    runXfer(1'b0, 1'b0, 1'b1, 10'h151, 8, 3, -1, 4, "R2 R10 7-bit read");
    runXfer(1'b0, 1'b0, 1'b0, 10'h013, 5, 2, -1, 3, "R5 width 5 write");
    runXfer(1'b0, 1'b0, 1'b1, 10'h07E, 3, 2, -1, 5, "R5 width 3 read");
    runXfer(1'b0, 1'b0, 1'b0, 10'h022, 0, 1, -1, 2, "R5 width 0 as 8");
    runXfer(1'b1, 1'b0, 1'b0, 10'h2C7, 8, 2, -1, 3, "R6 10-bit write");
    runXfer(1'b1, 1'b0, 1'b1, 10'h1B4, 6, 2, -1, 3, "R7 10-bit read");
    runXfer(1'b1, 1'b1, 1'b0, 10'h3FF, 7, 2, -1, 4, "R8 free write");
    runXfer(1'b0, 1'b1, 1'b1, 10'h000, 8, 1, -1, 4, "R8 free read");
    runXfer(1'b0, 1'b0, 1'b0, 10'h044, 8, 2, 0, 3, "R9 address nack");
    runXfer(1'b1, 1'b0, 1'b1, 10'h0F0, 8, 2, 0, 3, "R9 10-bit header nack");
    runXfer(1'b0, 1'b0, 1'b0, 10'h031, 8, 3, 2, 3, "R9 data nack");
    runXfer(1'b0, 1'b0, 1'b0, 10'h06D, 8, 0, -1, 3, "R13 address only");
    runXfer(1'b0, 1'b1, 1'b0, 10'h000, 8, 0, -1, 3, "R13 free empty");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule